// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is one stage of a synchronous up-counter, four bits wide by default. A parameter picks the count sequence: binary, from 0 to 15, or decade, from 0 to 9. Every state bit changes together on the rising clock edge. Nothing changes between edges.

Three controls act on each edge, in a fixed order of priority:

1. An active-low synchronous clear.
2. An active-low synchronous parallel load from a data input.
3. A count step.

The count step needs two enables. The first, the parallel enable, only gates counting. The second, the carry-chain enable, gates counting and also qualifies the carry output. The carry output is high while the carry-chain enable is high and the state sits at the terminal count. It is combinational, so it can feed the carry-chain enable of the next stage directly. This lets identical stages form a wider synchronous counter with no extra gating.

Because the clear is synchronous, the count length can be shortened. An active-low decode of any chosen state, fed back into the clear, returns the stage to zero on the edge after that state is reached. The block has no data stream, so it has no valid/ready interface: every pin is a plain level-sensitive control or status line.

Top module: `sync_preset_counter`

## Requirements
- R1: The state changes only at a rising clock edge. Input changes between edges leave the outputs untouched.
- R2: `clr_n` low at an edge gives `q` = 0, whatever the load, enable and data levels are.
- R3: `load_n` low with `clr_n` high at an edge copies `din` into `q`, whatever the enable levels are. In decade mode this includes the values 10 to 15.
- R4: With `clr_n` and `load_n` both high, `q` advances by one only when `cnt_en` and `chain_en` are both high. Otherwise it holds.
- R5: In binary mode (MODE = MODE_BIN), an enabled step from 15 gives 0.
- R6: In decade mode (MODE = MODE_DEC), an enabled step from 9 gives 0. From a loaded value of 10 to 15 the state keeps stepping and wraps from 15 to 0. The carry stays low in those six states.
- R7: `carry_out` is 1 exactly when `chain_en` is 1 and `q` equals the terminal count: 15 in binary mode, 9 in decade mode. It does not depend on `cnt_en`, and it follows `chain_en` within the same cycle.
- R8: Two binary stages can be chained. The low stage has `chain_en` tied high, the high stage takes `chain_en` from the low stage's `carry_out`, and both share the clock, `cnt_en` and the clear. Chained this way they count as one 8-bit counter, with the high stage's `carry_out` high at 255.
- R9: Driving `clr_n` from the inverted decode `q == 5` makes the stage repeat the sequence 0, 1, 2, 3, 4, 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Parallel count enable; gates counting only |
| chain_en | input | 1 | Carry-chain enable; gates counting and the carry output |
| din | input | DW | Preset value |
| q | output | DW | Counter state |
| carry_out | output | 1 | Terminal-count carry, qualified by `chain_en` |

## Verification
The bench builds the stage with its default binary mode and again with MODE = MODE_DEC. The binary build reaches the 15-to-0 wrap. The decade build reaches the 9-to-0 wrap and the out-of-range states 10 to 15 that only a load can enter. Two further binary copies are chained carry-to-enable and counted past 255, which exercises the carry crossing between stages. A fifth binary copy has its clear wired to a decode of its own state, which exercises the shortened count.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic {
    MODE_BIN = 1'b0,
    MODE_DEC = 1'b1
  } cnt_mode_e;

  localparam int DEC_LAST = 9;
endpackage

// File: rtl/spc_term.sv
module spc_term
  import spc_pkg::*;
#(
  parameter int        DW   = 4,
  parameter cnt_mode_e MODE = MODE_BIN
) (
  input  logic [DW-1:0] q,
  input  logic          chain_en,
  output logic          at_term,
  output logic          carry_out
);
  generate
    if (MODE == MODE_DEC) begin : g_dec
      localparam logic [DW-1:0] LAST_V = DW'(DEC_LAST);
      assign at_term = (q == LAST_V);
    end else begin : g_bin
      assign at_term = &q;
    end
  endgenerate

  assign carry_out = chain_en & at_term;

  always_comb begin
    if (!chain_en) AST_CARRY_NEEDS_CHAIN: assert (!carry_out); // R7
  end
endmodule

// File: rtl/spc_next.sv
module spc_next #(
  parameter int DW = 4
) (
  input  logic          clr_n,
  input  logic          load_n,
  input  logic          cnt_en,
  input  logic          chain_en,
  input  logic          at_term,
  input  logic [DW-1:0] q,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q_nxt
);
  logic step;
  assign step = cnt_en & chain_en;

  always_comb begin
    if (!clr_n)       q_nxt = '0;
    else if (!load_n) q_nxt = din;
    else if (step)    q_nxt = at_term ? '0 : q + 1'b1;
    else              q_nxt = q;
  end
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
  import spc_pkg::*;
#(
  parameter int        DW   = 4,
  parameter cnt_mode_e MODE = MODE_BIN
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          load_n,
  input  logic          cnt_en,
  input  logic          chain_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q,
  output logic          carry_out
);
  localparam logic [DW-1:0] TERM_V = (MODE == MODE_DEC) ? DW'(DEC_LAST) : {DW{1'b1}};

  logic [DW-1:0] q_r;
  logic [DW-1:0] q_nxt;
  logic          at_term;

  spc_term #(.DW(DW), .MODE(MODE)) term_u (
    .q         (q_r),
    .chain_en  (chain_en),
    .at_term   (at_term),
    .carry_out (carry_out)
  );

  spc_next #(.DW(DW)) next_u (
    .clr_n    (clr_n),
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .chain_en (chain_en),
    .at_term  (at_term),
    .q        (q_r),
    .din      (din),
    .q_nxt    (q_nxt)
  );

  always_ff @(posedge clk) q_r <= q_nxt;

  assign q = q_r;

  // Checks are armed only after the first clear, since the state is unknown before it.
  logic chk_armed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) chk_armed <= 1'b1;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!chk_armed)
    !clr_n |=> (q == '0)); // R2
  AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!chk_armed)
    (clr_n && !load_n) |=> (q == $past(din))); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!chk_armed)
    (clr_n && load_n && !(cnt_en && chain_en)) |=> $stable(q)); // R4
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!chk_armed)
    (clr_n && load_n && cnt_en && chain_en) |=>
      (q == (($past(q) == TERM_V) ? '0 : DW'($past(q) + 1'b1)))); // R5
  AST_CARRY_AT_TERM: assert property (@(posedge clk) disable iff (!chk_armed)
    carry_out |-> (chain_en && q == TERM_V)); // R7
endmodule

// File: tb/sync_preset_counter_tb_top.sv
module sync_preset_counter_tb_top;
  import spc_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;

  // binary stage under test
  logic       b_clr_n = 1'b1, b_load_n = 1'b1, b_en = 1'b0, b_chain = 1'b0;
  logic [3:0] b_din = '0, b_q;
  logic       b_co;
  sync_preset_counter #(.DW(4), .MODE(MODE_BIN)) dut_i (
    .clk(clk), .clr_n(b_clr_n), .load_n(b_load_n), .cnt_en(b_en), .chain_en(b_chain),
    .din(b_din), .q(b_q), .carry_out(b_co));

  // decade stage
  logic       d_clr_n = 1'b1, d_load_n = 1'b1, d_en = 1'b0, d_chain = 1'b0;
  logic [3:0] d_din = '0, d_q;
  logic       d_co;
  sync_preset_counter #(.DW(4), .MODE(MODE_DEC)) dec_i (
    .clk(clk), .clr_n(d_clr_n), .load_n(d_load_n), .cnt_en(d_en), .chain_en(d_chain),
    .din(d_din), .q(d_q), .carry_out(d_co));

  // two chained binary stages
  logic       c_clr_n = 1'b1, c_en = 1'b0;
  logic [3:0] lo_q, hi_q;
  logic       lo_co, hi_co;
  sync_preset_counter #(.DW(4), .MODE(MODE_BIN)) lo_i (
    .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .cnt_en(c_en), .chain_en(1'b1),
    .din(4'd0), .q(lo_q), .carry_out(lo_co));
  sync_preset_counter #(.DW(4), .MODE(MODE_BIN)) hi_i (
    .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .cnt_en(c_en), .chain_en(lo_co),
    .din(4'd0), .q(hi_q), .carry_out(hi_co));

  // shortened count: clear fed by decode of state 5
  logic       t_rst_n = 1'b1;
  logic [3:0] t_q;
  logic       t_co;
  logic       t_clr_n;
  assign t_clr_n = t_rst_n & ~(t_q == 4'd5);
  sync_preset_counter #(.DW(4), .MODE(MODE_BIN)) trunc_i (
    .clk(clk), .clr_n(t_clr_n), .load_n(1'b1), .cnt_en(1'b1), .chain_en(1'b1),
    .din(4'd0), .q(t_q), .carry_out(t_co));

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    b_clr_n = 1'b0; b_load_n = 1'b0; b_din = 4'd7; b_en = 1'b1; b_chain = 1'b1;
    step();
    chk("R2 clear beats load", b_q, 0);
    chk("R7 carry low at 0", b_co, 0);
    b_clr_n = 1'b1; b_load_n = 1'b1; b_en = 1'b0; b_chain = 1'b0;
  endtask

  task automatic t_binary_count();
    b_en = 1'b1; b_chain = 1'b1;
    for (int i = 0; i < 16; i++) begin
      chk("R4 binary count", b_q, i);
      chk("R7 binary carry", b_co, (i == 15) ? 1 : 0);
      step();
    end
    chk("R5 wrap 15 to 0", b_q, 0);
  endtask

  task automatic t_enables();
    b_load_n = 1'b0; b_din = 4'd15; b_en = 1'b0; b_chain = 1'b0;
    step();
    chk("R3 load with enables low", b_q, 15);
    b_load_n = 1'b1; b_chain = 1'b1;
    #1;
    chk("R7 carry ignores cnt_en", b_co, 1);
    step();
    chk("R4 hold with cnt_en low", b_q, 15);
    b_chain = 1'b0; b_en = 1'b1;
    #1;
    chk("R7 carry follows chain_en", b_co, 0);
    step();
    chk("R4 hold with chain_en low", b_q, 15);
  endtask

  task automatic t_between_edges();
    b_load_n = 1'b0; b_din = 4'd3; b_en = 1'b1; b_chain = 1'b1;
    #5;
    chk("R1 no change before edge", b_q, 15);
    b_clr_n = 1'b0;
    #3;
    chk("R1 clear waits for edge", b_q, 15);
    b_clr_n = 1'b1;
    step();
    chk("R3 load applied at edge", b_q, 3);
    b_load_n = 1'b1; b_en = 1'b0;
  endtask

  task automatic t_decade();
    d_clr_n = 1'b0;
    step();
    chk("R2 decade clear", d_q, 0);
    d_clr_n = 1'b1; d_en = 1'b1; d_chain = 1'b1;
    for (int i = 0; i < 10; i++) begin
      chk("R6 decade count", d_q, i);
      chk("R7 decade carry", d_co, (i == 9) ? 1 : 0);
      step();
    end
    chk("R6 wrap 9 to 0", d_q, 0);
    d_load_n = 1'b0; d_din = 4'd12;
    step();
    chk("R3 decade load 12", d_q, 12);
    d_load_n = 1'b1;
    for (int i = 12; i < 16; i++) begin
      chk("R6 out of range state", d_q, i);
      chk("R6 carry low out of range", d_co, 0);
      step();
    end
    chk("R6 wrap 15 to 0", d_q, 0);
  endtask

  task automatic t_cascade();
    c_clr_n = 1'b0;
    step();
    c_clr_n = 1'b1; c_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      chk("R8 chained value", {hi_q, lo_q}, i % 256);
      chk("R8 chained carry", hi_co, ((i % 256) == 255) ? 1 : 0);
      step();
    end
    c_en = 1'b0;
    step();
    chk("R8 chained hold", {hi_q, lo_q}, 300 % 256);
  endtask

  task automatic t_truncated();
    t_rst_n = 1'b0;
    step();
    t_rst_n = 1'b1;
    for (int i = 0; i < 14; i++) begin
      chk("R9 shortened sequence", t_q, i % 6);
      step();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    t_binary_count();
    t_enables();
    t_between_edges();
    t_decade();
    t_cascade();
    t_truncated();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule